// File: doc/BRIEF.md
# Processor-to-PCI Request Translator

This block takes one request at a time from a 64-bit, big-endian processor bus and replays it as a PCI memory transaction on a 32-bit, little-endian bus. The same clock drives both sides. A request is either a line burst or a short access. A line burst moves 32 bytes from an address on an 8-byte boundary. A short access moves 1 to 8 bytes from any byte address. The block issues the address phase and the data phases with FRAME#, IRDY# and TRDY# sequencing. It places every byte on the lane that matches its byte address, drives C/BE# with the command and the per-word enables, and drives even parity one clock behind each phase it owns. After the last data phase it tells the processor side that the request is complete.

Processor data is left-justified in big-endian order. The byte at the request's start address sits in bits 63:56, the next byte in bits 55:48, and so on. For a burst, the 32-byte stream is split into four doublewords. During a write burst the block asks for each doubleword through a select output, and the processor side presents that doubleword on the same cycle. Write data must stay unchanged while the request is in progress. Incoming parity is never examined, and arbitration and configuration cycles are outside this block.

Top module: `cpu2pci_xlate`

## Requirements
- R1: `req_ready_o` is high only when the block is idle, and a request is taken on a clock where `req_valid_i` and `req_ready_o` are both high. After reset the block is idle, FRAME# and IRDY# are high, `done_o`, `rvalid_o`, `ad_oe_o` and `par_oe_o` are low, and a reset during a transaction returns the block to this state.
- R2: The cycle after a request is taken is the address phase. FRAME# is low, IRDY# is high, AD carries the start address with bits 1:0 cleared, AD is driven, and C/BE# carries 4'b0110 for a read or 4'b0111 for a write.
- R3: A burst produces exactly 8 data phases on consecutive word addresses from the start address, with C/BE# at 4'b0000 in every phase.
- R4: For a short access at address A of length L, the data phases cover word addresses from floor(A/4) to floor((A+L-1)/4) in rising order. In each phase, C/BE# bit n is low exactly when byte address 4W+n lies in [A, A+L).
- R5: On writes, the byte at address A+k (stream byte k) goes out on AD lane (A+k) mod 4, which is bits 8n+7:8n for lane n. Stream byte k is taken from doubleword k/8, at bits 63-8(k mod 8) down to 56-8(k mod 8). Lanes that are not enabled drive 8'h00. During a burst, `wr_dw_sel_o` equals the data-phase index divided by 2.
- R6: On reads, the byte taken from AD lane n at address 4W+n is returned as stream byte 4W+n-A in the same left-justified order, and unrequested bytes read as zero. For a burst read, `rvalid_o` pulses with each completed doubleword, one cycle after the data phase that finishes it. A short read gives one pulse, in the cycle after its last phase.
- R7: IRDY# stays low through every data phase, including wait states. While TRDY# is high on a write, AD and C/BE# hold their values.
- R8: FRAME# stays low until the final data phase, is high during that phase, and is never raised unless IRDY# is low.
- R9: `par_oe_o` is high exactly one cycle after each cycle with `ad_oe_o` high. In that cycle, `par_o` equals the XOR of the 32 AD bits and the 4 C/BE# bits from the previous cycle.
- R10: `done_o` pulses for one cycle in the cycle after the last data phase completes. FRAME# and IRDY# are high during that cycle, and `req_ready_o` rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both buses |
| rst_i | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Processor request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_burst_i | input | 1 | 1 = 32-byte line burst |
| req_addr_i | input | 32 | Start byte address |
| req_len_i | input | 4 | Byte count 1..8 for a short access |
| req_wdata_i | input | 64 | Write doubleword, big-endian, left-justified |
| wr_dw_sel_o | output | 2 | Doubleword of the burst wanted on req_wdata_i |
| rdata_o | output | 64 | Read doubleword, big-endian, left-justified |
| rvalid_o | output | 1 | rdata_o holds a completed doubleword |
| done_o | output | 1 | Request finished |
| ad_o | output | 32 | PCI AD out |
| ad_i | input | 32 | PCI AD in |
| ad_oe_o | output | 1 | AD driven by this block |
| cbe_n_o | output | 4 | PCI command / byte enables, active low |
| frame_n_o | output | 1 | PCI FRAME#, active low |
| irdy_n_o | output | 1 | PCI IRDY#, active low |
| trdy_n_i | input | 1 | PCI TRDY#, active low |
| par_o | output | 1 | Even parity over AD and C/BE# |
| par_oe_o | output | 1 | par_o driven |

## Verification
Some faults are visible in the very next data phase:
- A wrong beat counter shows up as a misplaced FRAME# release or a wrong enable pattern on C/BE#.
- A wrong offset or doubleword select shows up as bytes on the wrong AD lane.

A wrong stored read byte stays hidden until `rvalid_o` or `done_o` pulses, at most eight phases later, so read data is compared exactly at those pulses. Parity faults appear one clock late by design, so every phase is checked against the AD and C/BE# values captured in the cycle before.

// File: rtl/xl_pkg.sv
package xl_pkg;
    localparam int ADDR_W     = 32;
    localparam int CPU_W      = 64;
    localparam int PCI_W      = 32;
    localparam int LANES      = PCI_W / 8;
    localparam int CPU_BYTES  = CPU_W / 8;
    localparam int LINE_BEATS = 8;
    localparam int BEAT_W     = $clog2(LINE_BEATS);
    localparam int LEN_W      = $clog2(CPU_BYTES) + 1;
    localparam int OFF_W      = $clog2(LANES);
    localparam int SEL_W      = $clog2(LINE_BEATS * LANES / CPU_BYTES);

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_TURN
    } xl_state_e;

    typedef struct packed {
        xl_state_e          st;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   len;
        logic               burst;
        logic               write;
        logic [BEAT_W-1:0]  beat;
        logic [CPU_W-1:0]   rdata;
        logic               rvalid;
        logic               done;
        logic               par;
        logic               par_oe;
    } xl_regs_t;
endpackage

// File: rtl/xl_enables.sv
module xl_enables
    import xl_pkg::*;
(
    input  logic [OFF_W-1:0]  off_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              burst_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [LANES-1:0]  be_o,
    output logic [BEAT_W-1:0] last_o
);
    localparam int MASK_W = LANES * LINE_BEATS;
    localparam int END_W  = BEAT_W + OFF_W;

    logic [MASK_W-1:0] span;
    logic [END_W-1:0]  end_byte;

    // span marks every requested byte relative to the first word's lane 0
    always_comb begin
        span     = ((MASK_W'(1) << len_i) - MASK_W'(1)) << off_i;
        end_byte = END_W'(off_i) + END_W'(len_i) - END_W'(1);
        if (burst_i) begin
            be_o   = '1;
            last_o = BEAT_W'(LINE_BEATS - 1);
        end else begin
            be_o   = span[{beat_i, {OFF_W{1'b0}}} +: LANES];
            last_o = end_byte[END_W-1:OFF_W];
        end
    end
endmodule

// File: rtl/xl_lanes.sv
module xl_lanes
    import xl_pkg::*;
(
    input  logic [BEAT_W-1:0] beat_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [CPU_W-1:0]  wdata_i,
    input  logic [PCI_W-1:0]  ad_i,
    input  logic [CPU_W-1:0]  rdata_i,
    output logic [PCI_W-1:0]  ad_o,
    output logic [CPU_W-1:0]  rdata_o
);
    localparam int IDX_W = BEAT_W + OFF_W;
    localparam int JW    = $clog2(CPU_BYTES);

    // write path: each PCI lane picks its big-endian stream byte
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [IDX_W-1:0] idx;
        logic [JW-1:0]    j;
        assign idx = {beat_i, OFF_W'(l)} - IDX_W'(off_i);
        assign j   = idx[JW-1:0];
        assign ad_o[8*l +: 8] = be_i[l] ? wdata_i[8*(CPU_BYTES-1-int'(j)) +: 8] : 8'h00;
    end

    // read path: enabled lanes land at their stream position
    always_comb begin
        logic [IDX_W-1:0] k;
        k       = '0;
        rdata_o = rdata_i;
        for (int l = 0; l < LANES; l++) begin
            k = {beat_i, OFF_W'(l)} - IDX_W'(off_i);
            if (be_i[l]) begin
                rdata_o[8*(CPU_BYTES-1-int'(k[JW-1:0])) +: 8] = ad_i[8*l +: 8];
            end
        end
    end
endmodule

// File: rtl/cpu2pci_xlate.sv
module cpu2pci_xlate
    import xl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic              req_burst_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [LEN_W-1:0]  req_len_i,
    input  logic [CPU_W-1:0]  req_wdata_i,
    output logic [SEL_W-1:0]  wr_dw_sel_o,
    output logic [CPU_W-1:0]  rdata_o,
    output logic              rvalid_o,
    output logic              done_o,
    output logic [PCI_W-1:0]  ad_o,
    input  logic [PCI_W-1:0]  ad_i,
    output logic              ad_oe_o,
    output logic [3:0]        cbe_n_o,
    output logic              frame_n_o,
    output logic              irdy_n_o,
    input  logic              trdy_n_i,
    output logic              par_o,
    output logic              par_oe_o
);
    xl_regs_t r_q, r_d;

    logic [OFF_W-1:0]  off;
    logic [LANES-1:0]  be;
    logic [BEAT_W-1:0] last_beat;
    logic [PCI_W-1:0]  ad_wr;
    logic [CPU_W-1:0]  rdata_mrg;
    logic              xfer;

    assign off = r_q.burst ? '0 : r_q.addr[OFF_W-1:0];

    xl_enables i_enables (
        .off_i  (off),
        .len_i  (r_q.len),
        .burst_i(r_q.burst),
        .beat_i (r_q.beat),
        .be_o   (be),
        .last_o (last_beat)
    );

    xl_lanes i_lanes (
        .beat_i (r_q.beat),
        .off_i  (off),
        .be_i   (be),
        .wdata_i(req_wdata_i),
        .ad_i   (ad_i),
        .rdata_i(r_q.rdata),
        .ad_o   (ad_wr),
        .rdata_o(rdata_mrg)
    );

    // PCI pin decode from registered state
    always_comb begin
        ad_o      = '0;
        ad_oe_o   = 1'b0;
        cbe_n_o   = 4'hF;
        frame_n_o = 1'b1;
        irdy_n_o  = 1'b1;
        case (r_q.st)
            ST_ADDR: begin
                ad_o      = {r_q.addr[ADDR_W-1:OFF_W], OFF_W'(0)};
                ad_oe_o   = 1'b1;
                cbe_n_o   = r_q.write ? CMD_MEM_WR : CMD_MEM_RD;
                frame_n_o = 1'b0;
            end
            ST_DATA: begin
                irdy_n_o  = 1'b0;
                frame_n_o = (r_q.beat == last_beat);
                cbe_n_o   = ~be;
                if (r_q.write) begin
                    ad_o    = ad_wr;
                    ad_oe_o = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign xfer = (r_q.st == ST_DATA) && !trdy_n_i;

    // next-state computation
    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.rvalid = 1'b0;
        r_d.par    = ^{ad_o, cbe_n_o};
        r_d.par_oe = ad_oe_o;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    r_d.st    = ST_ADDR;
                    r_d.addr  = req_addr_i;
                    r_d.len   = req_len_i;
                    r_d.burst = req_burst_i;
                    r_d.write = req_write_i;
                    r_d.beat  = '0;
                    r_d.rdata = '0;
                end
            end
            ST_ADDR: r_d.st = ST_DATA;
            ST_DATA: begin
                if (xfer) begin
                    if (!r_q.write) r_d.rdata = rdata_mrg;
                    if (r_q.beat == last_beat) begin
                        r_d.st     = ST_TURN;
                        r_d.done   = 1'b1;
                        r_d.rvalid = !r_q.write;
                    end else begin
                        r_d.beat   = r_q.beat + BEAT_W'(1);
                        r_d.rvalid = !r_q.write && r_q.burst && r_q.beat[0];
                    end
                end
            end
            ST_TURN: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) r_q <= '0;
        else       r_q <= r_d;
    end

    assign req_ready_o = (r_q.st == ST_IDLE);
    assign wr_dw_sel_o = r_q.burst ? r_q.beat[BEAT_W-1 -: SEL_W] : '0;
    assign rdata_o     = r_q.rdata;
    assign rvalid_o    = r_q.rvalid;
    assign done_o      = r_q.done;
    assign par_o       = r_q.par;
    assign par_oe_o    = r_q.par_oe;

    // protocol checks
    assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        req_ready_o |-> (frame_n_o && irdy_n_o && !ad_oe_o));

    assert_burst_all_lanes_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!irdy_n_o && r_q.burst) |-> (cbe_n_o == 4'b0000));

    assert_irdy_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!irdy_n_o && trdy_n_i) |=> !irdy_n_o);

    assert_wdata_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!irdy_n_o && trdy_n_i && ad_oe_o) |=> ($stable(ad_o) && $stable(cbe_n_o)));

    assert_frame_release_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(frame_n_o) |-> !irdy_n_o);

    assert_done_after_last_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> $past(!irdy_n_o && !trdy_n_i && frame_n_o));
endmodule

// File: tb/test_cpu2pci_xlate.sv
module test_cpu2pci_xlate;
    import xl_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // {burst, write, addr, len, beats, first-phase enables}
    localparam logic [45:0] VECS [NVEC] = '{
        {1'b0, 1'b1, 32'h1000_0003, 4'd8, 4'd3, 4'b1000},
        {1'b0, 1'b0, 32'h2000_0105, 4'd2, 4'd1, 4'b0110},
        {1'b0, 1'b1, 32'h0000_0040, 4'd1, 4'd1, 4'b0001},
        {1'b0, 1'b0, 32'h0000_0087, 4'd5, 4'd2, 4'b1000},
        {1'b1, 1'b1, 32'h3000_0020, 4'd8, 4'd8, 4'b1111},
        {1'b1, 1'b0, 32'h3000_0048, 4'd8, 4'd8, 4'b1111},
        {1'b0, 1'b0, 32'h0000_0010, 4'd4, 4'd1, 4'b1111},
        {1'b0, 1'b1, 32'h0000_00F6, 4'd4, 4'd2, 4'b1100},
        {1'b0, 1'b1, 32'h0000_0200, 4'd8, 4'd2, 4'b1111},
        {1'b0, 1'b0, 32'h0000_0305, 4'd8, 4'd3, 4'b1110}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write, req_burst;
    logic [31:0] req_addr;
    logic [3:0]  req_len;
    logic [63:0] req_wdata;
    logic [1:0]  wr_dw_sel;
    logic [63:0] rdata;
    logic        rvalid, done;
    logic [31:0] ad_out, ad_in;
    logic        ad_oe;
    logic [3:0]  cbe_n;
    logic        frame_n, irdy_n, trdy_n, par, par_oe;
    logic [63:0] wdw [4];

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb req_wdata = wdw[wr_dw_sel];

    cpu2pci_xlate i_cpu2pci_xlate (
        .clk_i(clk), .rst_i(rst),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_write_i(req_write), .req_burst_i(req_burst),
        .req_addr_i(req_addr), .req_len_i(req_len), .req_wdata_i(req_wdata),
        .wr_dw_sel_o(wr_dw_sel), .rdata_o(rdata), .rvalid_o(rvalid), .done_o(done),
        .ad_o(ad_out), .ad_i(ad_in), .ad_oe_o(ad_oe), .cbe_n_o(cbe_n),
        .frame_n_o(frame_n), .irdy_n_o(irdy_n), .trdy_n_i(trdy_n),
        .par_o(par), .par_oe_o(par_oe)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // target memory contents, derived from the byte address
    function automatic logic [7:0] tgt(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    function automatic logic [3:0] be_exp(input logic bu, input logic [31:0] ad, input logic [3:0] ln, input int b);
        logic [31:0] base, a;
        logic [3:0]  be;
        base = {ad[31:2], 2'b00} + 32'(4*b);
        for (int n = 0; n < 4; n++) begin
            a = base + 32'(n);
            be[n] = bu || (a >= ad && a < ad + 32'(ln));
        end
        return be;
    endfunction

    function automatic logic [31:0] wexp(input logic bu, input logic [31:0] ad, input logic [3:0] ln, input int b);
        logic [31:0] base, a, k, w;
        w = '0;
        base = {ad[31:2], 2'b00} + 32'(4*b);
        for (int n = 0; n < 4; n++) begin
            a = base + 32'(n);
            k = a - ad;
            if (bu || (a >= ad && a < ad + 32'(ln)))
                w[8*n +: 8] = wdw[k[4:3]][8*(7-int'(k[2:0])) +: 8];
        end
        return w;
    endfunction

    function automatic logic [31:0] rword(input logic [31:0] ad, input int b);
        logic [31:0] base, w;
        base = {ad[31:2], 2'b00} + 32'(4*b);
        for (int n = 0; n < 4; n++) w[8*n +: 8] = tgt(base + 32'(n));
        return w;
    endfunction

    function automatic logic [63:0] rdexp(input logic bu, input logic [31:0] ad, input logic [3:0] ln, input int d);
        logic [63:0] r;
        int k;
        r = '0;
        for (int j = 0; j < 8; j++) begin
            k = 8*d + j;
            if (bu || k < int'(ln)) r[8*(7-j) +: 8] = tgt(ad + 32'(k));
        end
        return r;
    endfunction

    task automatic run_req(input logic bu, input logic wr, input logic [31:0] ad, input logic [3:0] ln,
                           input int nb, input logic [3:0] be0, input int seed, input int wmax);
        int b, w, pbeat, wb;
        logic pe, poe, rvexp;
        for (int d = 0; d < 4; d++) wdw[d] = 64'hF0E1_D2C3_B4A5_9687 ^ {8{8'(seed*16 + d)}};
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready while idle", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_burst = bu; req_addr = ad; req_len = ln;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1 busy after accept", req_ready, 0);
        chk(frame_n == 1'b0 && irdy_n == 1'b1, "R2 address phase framing", {frame_n, irdy_n}, 2'b01);
        chk(ad_out == {ad[31:2], 2'b00} && ad_oe, "R2 address", ad_out, {ad[31:2], 2'b00});
        chk(cbe_n == (wr ? 4'b0111 : 4'b0110), "R2 command", cbe_n, wr ? 4'b0111 : 4'b0110);
        pe = ^{ad_out, cbe_n}; poe = 1'b1;
        b = 0; w = 0; pbeat = -1;
        while (b < nb) begin
            @(negedge clk);
            chk(par_oe == poe && (!poe || par == pe), "R9 parity", {par_oe, par}, {poe, pe});
            rvexp = !wr && bu && pbeat >= 0 && pbeat[0];
            chk(rvalid == rvexp, "R6 rvalid pulse", rvalid, rvexp);
            if (rvexp) chk(rdata == rdexp(bu, ad, ln, pbeat/2), "R6 burst read doubleword", rdata, rdexp(bu, ad, ln, pbeat/2));
            pbeat = -1;
            chk(irdy_n == 1'b0, "R7 IRDY during data phase", irdy_n, 0);
            chk(frame_n == (b == nb-1), "R8 FRAME release", frame_n, (b == nb-1));
            if (bu) chk(cbe_n == 4'b0000, "R3 burst enables", cbe_n, 0);
            else    chk(cbe_n == ~((b == 0) ? be0 : be_exp(bu, ad, ln, b)), "R4 short enables", cbe_n, ~((b == 0) ? be0 : be_exp(bu, ad, ln, b)));
            if (wr) begin
                chk(ad_out == wexp(bu, ad, ln, b) && ad_oe, "R5 write lanes", ad_out, wexp(bu, ad, ln, b));
            end else begin
                ad_in = rword(ad, b);
            end
            pe = ^{ad_out, cbe_n}; poe = ad_oe;
            wb = (((b + seed) % 3) == 0) ? wmax : 0;
            if (w < wb) begin
                trdy_n = 1'b1; w++;
            end else begin
                trdy_n = 1'b0; w = 0; pbeat = b; b++;
            end
        end
        @(negedge clk);
        trdy_n = 1'b1;
        chk(par_oe == poe && (!poe || par == pe), "R9 parity after last phase", {par_oe, par}, {poe, pe});
        chk(done == 1'b1, "R10 done pulse", done, 1);
        chk(frame_n && irdy_n, "R10 turnaround", {frame_n, irdy_n}, 2'b11);
        chk(req_ready == 1'b0, "R10 not ready in turnaround", req_ready, 0);
        if (!wr) begin
            chk(rvalid == 1'b1, "R6 final rvalid", rvalid, 1);
            chk(rdata == rdexp(bu, ad, ln, bu ? 3 : 0), "R6 read data", rdata, rdexp(bu, ad, ln, bu ? 3 : 0));
        end else begin
            chk(rvalid == 1'b0, "R6 no rvalid on write", rvalid, 0);
        end
        @(negedge clk);
        chk(req_ready && !done, "R10 back to idle", {req_ready, done}, 2'b10);
        chk(par_oe == 1'b0, "R9 no parity after undriven cycle", par_oe, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R10 watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_burst = 1'b0;
        req_addr = '0; req_len = 4'd1; trdy_n = 1'b1; ad_in = '0;
        for (int d = 0; d < 4; d++) wdw[d] = '0;
        repeat (3) @(negedge clk);
        chk(req_ready && frame_n && irdy_n, "R1 reset state pins", {req_ready, frame_n, irdy_n}, 3'b111);
        chk(!done && !rvalid && !ad_oe && !par_oe, "R1 reset state flags", {done, rvalid, ad_oe, par_oe}, 0);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            run_req(VECS[v][45], VECS[v][44], VECS[v][43:12], VECS[v][11:8],
                    int'(VECS[v][7:4]), VECS[v][3:0], v, v % 2);
        end

        // long wait states on a burst write and a crossing short read
        run_req(1'b1, 1'b1, 32'h0000_1000, 4'd8, 8, 4'b1111, 1, 3);
        run_req(1'b0, 1'b0, 32'h0000_0407, 4'd3, 2, 4'b1000, 2, 3);

        // reset in the address phase returns to idle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_burst = 1'b0; req_addr = 32'h40; req_len = 4'd4;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(req_ready && frame_n && irdy_n && !ad_oe, "R1 reset mid-transaction", {req_ready, frame_n, irdy_n, ad_oe}, 4'b1110);
        rst = 1'b0;
        run_req(1'b0, 1'b0, 32'h0000_0500, 4'd1, 1, 4'b0001, 4, 0);

        summary();
    end
endmodule